// File: doc/BRIEF.md
# Translation Permission and Fault Checker

This block sits directly after the translation lookup of an address translation unit. It receives the result of that lookup: a hit flag, plus the physical page number, the per-privilege-mode read and write enable masks and the two fault-on-access flags of the matching entry. It also receives the current request: its privilege mode, whether it is an instruction fetch or a data access, whether a data access is a write, and its virtual address. From these it builds the physical address and decides whether the access must fault. When it must, it reports the kind of fault and a small status flag word that exception handling can record.

All of these results are combinational, so the checker adds no cycle to the translation path. Alongside them, four saturating event counters track data-side misses and data-side protection events, split by reads and writes. The lookup storage itself and the dispatch of exceptions belong to neighbouring blocks.

Top module: `xlat_guard`

## Requirements
- R1: For a data access, `phys_addr` equals `ent_ppn` shifted left by `PAGE_SHIFT` (13), plus bits [12:0] of `virt_addr`.
- R2: For an instruction fetch, `phys_addr` is formed as in R1 but with its two lowest bits forced to zero.
- R3: A lookup miss (`lk_hit` low) with `req_valid` high gives `flt_valid`=1 and `flt_kind`=1 (miss), whatever the entry fields hold. `flt_status` bit 0 (write) is set only for a data write, and all other status bits are 0.
- R4: On a data write that hits, if `ent_wr_mask[priv_mode]` is 0, then `flt_kind`=2 (violation). `flt_status` has bit 0 (write) and bit 1 (violation) set, plus bit 3 (fault-on-write) if `ent_fow` is set.
- R5: On a data write that hits with `ent_wr_mask[priv_mode]` set and `ent_fow` set, `flt_kind`=3 (fault-on-access) and `flt_status` = bit 0 plus bit 3 (value 4'b1001).
- R6: On a data read that hits, if `ent_rd_mask[priv_mode]` is 0, then `flt_kind`=2. `flt_status` has bit 1 set, plus bit 2 (fault-on-read) if `ent_for` is set.
- R7: On a data read that hits with `ent_rd_mask[priv_mode]` set and `ent_for` set, `flt_kind`=3 and `flt_status` = bit 2 only (value 4'b0100).
- R8: An instruction fetch that hits faults only when `ent_rd_mask[priv_mode]` is 0, with `flt_kind`=2 and `flt_status`=0. `req_is_write`, `ent_wr_mask`, `ent_for` and `ent_fow` have no effect on a fetch.
- R9: When no fault applies, or when `req_valid` is low, `flt_valid`=0, `flt_kind`=0 and `flt_status`=0. While `req_valid` is low, the counters hold their value.
- R10: On each rising clock edge with `req_valid` high, the counters advance by one. `cnt_rd_miss` counts data-read misses and `cnt_wr_miss` counts data-write misses. `cnt_rd_viol` counts data reads with `flt_kind` 2 or 3, and `cnt_wr_viol` counts data writes with `flt_kind` 2 or 3. Fetch events are not counted.
- R11: Each counter stops at its all-ones value and stays there.
- R12: While `rst_n` is low, all counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the event counters |
| rst_n | input | 1 | Active-low reset of the counters |
| req_valid | input | 1 | A request is present this cycle |
| req_is_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| req_is_write | input | 1 | 1 = data write, 0 = data read (ignored on fetch) |
| priv_mode | input | MODE_W (2) | Current privilege mode, indexes the masks |
| virt_addr | input | VA_W (32) | Virtual address of the request |
| lk_hit | input | 1 | The lookup found a matching entry |
| ent_ppn | input | PPN_W (27) | Physical page number of the entry |
| ent_rd_mask | input | 2**MODE_W (4) | Read/execute enable, one bit per mode |
| ent_wr_mask | input | 2**MODE_W (4) | Write enable, one bit per mode |
| ent_for | input | 1 | Entry demands a fault on read |
| ent_fow | input | 1 | Entry demands a fault on write |
| phys_addr | output | PPN_W+PAGE_SHIFT (40) | Translated physical address |
| flt_valid | output | 1 | A fault is reported |
| flt_kind | output | 2 | 0 none, 1 miss, 2 violation, 3 fault-on-access |
| flt_status | output | 4 | bit0 write, bit1 violation, bit2 fault-on-read, bit3 fault-on-write |
| cnt_rd_miss | output | CNT_W (16) | Saturating count of data-read misses |
| cnt_wr_miss | output | CNT_W (16) | Saturating count of data-write misses |
| cnt_rd_viol | output | CNT_W (16) | Saturating count of data-read protection events |
| cnt_wr_viol | output | CNT_W (16) | Saturating count of data-write protection events |

## Verification
The address, fault valid, fault kind and status word are due in the same cycle as the request, because they depend only on the inputs. The counters reflect a request after the next rising edge. The bench applies each vector at the falling edge and samples 1 ns later. At that point it compares the combinational results against the vector just applied, and the counters against a model that holds every request accepted up to the previous rising edge. Only after that comparison does it fold the current vector into its counts. The counter width is lowered to 4 bits on the bench instance so that saturation is reached with a short run of misses.

// File: rtl/xg_pkg.sv
package xg_pkg;

  typedef enum logic [1:0] {
    FK_NONE = 2'd0,
    FK_MISS = 2'd1,
    FK_ACV  = 2'd2,
    FK_FOA  = 2'd3
  } fault_kind_e;

  localparam int ST_W   = 4;
  localparam int ST_WR  = 0;
  localparam int ST_ACV = 1;
  localparam int ST_FOR = 2;
  localparam int ST_FOW = 3;

  localparam int N_EVT  = 4;
  localparam int EV_RD_MISS = 0;
  localparam int EV_WR_MISS = 1;
  localparam int EV_RD_VIOL = 2;
  localparam int EV_WR_VIOL = 3;

  // low bits of the in-page offset cleared for instruction fetches
  function automatic logic [1:0] fetch_lsb_mask(input logic is_fetch);
    return is_fetch ? 2'b00 : 2'b11;
  endfunction

  function automatic logic is_protect_kind(input fault_kind_e k);
    return (k == FK_ACV) || (k == FK_FOA);
  endfunction

endpackage

// File: rtl/xg_addr.sv
module xg_addr #(
  parameter int VA_W       = 32,
  parameter int PPN_W      = 27,
  parameter int PAGE_SHIFT = 13,
  localparam int PA_W      = PPN_W + PAGE_SHIFT
) (
  input  logic [VA_W-1:0]  virt_addr,
  input  logic [PPN_W-1:0] ppn,
  input  logic             is_fetch,
  output logic [PA_W-1:0]  phys_addr
);
  import xg_pkg::*;

  logic [PAGE_SHIFT-1:0] offs;

  always_comb begin
    offs      = virt_addr[PAGE_SHIFT-1:0];
    offs[1:0] = offs[1:0] & fetch_lsb_mask(is_fetch);
    phys_addr = {ppn, offs};
  end

endmodule

// File: rtl/xg_classify.sv
module xg_classify #(
  parameter int MODE_W = 2,
  localparam int NMODE = 1 << MODE_W
) (
  input  logic                  hit,
  input  logic                  is_fetch,
  input  logic                  is_write,
  input  logic [MODE_W-1:0]     mode,
  input  logic [NMODE-1:0]      rd_mask,
  input  logic [NMODE-1:0]      wr_mask,
  input  logic                  f_on_rd,
  input  logic                  f_on_wr,
  output xg_pkg::fault_kind_e   kind,
  output logic [xg_pkg::ST_W-1:0] stat
);
  import xg_pkg::*;

  logic rd_ok, wr_ok;

  always_comb begin
    rd_ok = rd_mask[mode];
    wr_ok = wr_mask[mode];
    kind  = FK_NONE;
    stat  = '0;
    if (!hit) begin
      kind         = FK_MISS;
      stat[ST_WR]  = !is_fetch && is_write;
    end else if (is_fetch) begin
      if (!rd_ok) kind = FK_ACV;
    end else if (is_write) begin
      if (!wr_ok) begin
        kind         = FK_ACV;
        stat[ST_WR]  = 1'b1;
        stat[ST_ACV] = 1'b1;
        stat[ST_FOW] = f_on_wr;
      end else if (f_on_wr) begin
        kind         = FK_FOA;
        stat[ST_WR]  = 1'b1;
        stat[ST_FOW] = 1'b1;
      end
    end else begin
      if (!rd_ok) begin
        kind         = FK_ACV;
        stat[ST_ACV] = 1'b1;
        stat[ST_FOR] = f_on_rd;
      end else if (f_on_rd) begin
        kind         = FK_FOA;
        stat[ST_FOR] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/xg_sat_ctr.sv
module xg_sat_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] TOP = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      count <= '0;
    else if (inc && count != TOP)
      count <= count + 1'b1;
  end

endmodule

// File: rtl/xlat_guard.sv
module xlat_guard #(
  parameter int VA_W       = 32,
  parameter int PPN_W      = 27,
  parameter int PAGE_SHIFT = 13,
  parameter int MODE_W     = 2,
  parameter int CNT_W      = 16,
  localparam int PA_W      = PPN_W + PAGE_SHIFT,
  localparam int NMODE     = 1 << MODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_is_fetch,
  input  logic              req_is_write,
  input  logic [MODE_W-1:0] priv_mode,
  input  logic [VA_W-1:0]   virt_addr,
  input  logic              lk_hit,
  input  logic [PPN_W-1:0]  ent_ppn,
  input  logic [NMODE-1:0]  ent_rd_mask,
  input  logic [NMODE-1:0]  ent_wr_mask,
  input  logic              ent_for,
  input  logic              ent_fow,
  output logic [PA_W-1:0]   phys_addr,
  output logic              flt_valid,
  output logic [1:0]        flt_kind,
  output logic [3:0]        flt_status,
  output logic [CNT_W-1:0]  cnt_rd_miss,
  output logic [CNT_W-1:0]  cnt_wr_miss,
  output logic [CNT_W-1:0]  cnt_rd_viol,
  output logic [CNT_W-1:0]  cnt_wr_viol
);
  import xg_pkg::*;

  fault_kind_e          raw_kind;
  logic [ST_W-1:0]      raw_stat;
  logic                 is_data_rd, is_data_wr;
  logic [N_EVT-1:0]     ev_hit;
  logic [CNT_W-1:0]     cnt [N_EVT];

  xg_addr #(.VA_W(VA_W), .PPN_W(PPN_W), .PAGE_SHIFT(PAGE_SHIFT)) u_addr (
    .virt_addr (virt_addr),
    .ppn       (ent_ppn),
    .is_fetch  (req_is_fetch),
    .phys_addr (phys_addr)
  );

  xg_classify #(.MODE_W(MODE_W)) u_cls (
    .hit      (lk_hit),
    .is_fetch (req_is_fetch),
    .is_write (req_is_write),
    .mode     (priv_mode),
    .rd_mask  (ent_rd_mask),
    .wr_mask  (ent_wr_mask),
    .f_on_rd  (ent_for),
    .f_on_wr  (ent_fow),
    .kind     (raw_kind),
    .stat     (raw_stat)
  );

  assign flt_valid  = req_valid && (raw_kind != FK_NONE);
  assign flt_kind   = req_valid ? raw_kind : FK_NONE;
  assign flt_status = req_valid ? raw_stat : '0;

  assign is_data_rd = req_valid && !req_is_fetch && !req_is_write;
  assign is_data_wr = req_valid && !req_is_fetch &&  req_is_write;

  assign ev_hit[EV_RD_MISS] = is_data_rd && (raw_kind == FK_MISS);
  assign ev_hit[EV_WR_MISS] = is_data_wr && (raw_kind == FK_MISS);
  assign ev_hit[EV_RD_VIOL] = is_data_rd && is_protect_kind(raw_kind);
  assign ev_hit[EV_WR_VIOL] = is_data_wr && is_protect_kind(raw_kind);

  for (genvar g = 0; g < N_EVT; g++) begin : g_ctr
    xg_sat_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (ev_hit[g]),
      .count (cnt[g])
    );
  end

  assign cnt_rd_miss = cnt[EV_RD_MISS];
  assign cnt_wr_miss = cnt[EV_WR_MISS];
  assign cnt_rd_viol = cnt[EV_RD_VIOL];
  assign cnt_wr_viol = cnt[EV_WR_VIOL];

endmodule

// File: rtl/xg_check.sv
module xg_check #(
  parameter int PA_W  = 40,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_is_fetch,
  input logic             lk_hit,
  input logic [PA_W-1:0]  phys_addr,
  input logic             flt_valid,
  input logic [1:0]       flt_kind,
  input logic [3:0]       flt_status,
  input logic [CNT_W-1:0] cnt_rd_miss,
  input logic [CNT_W-1:0] cnt_rd_viol
);
  localparam logic [CNT_W-1:0] TOP = '1;

  // R2: fetch addresses are word aligned
  p_fetch_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_is_fetch) |-> (phys_addr[1:0] == 2'b00));

  // R3: a miss always reports the miss kind
  p_miss_kind_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !lk_hit) |-> (flt_valid && flt_kind == 2'd1));

  // R9: no request, no fault and counters hold
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!flt_valid && flt_kind == 2'd0 && flt_status == 4'd0));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(cnt_rd_miss) && $stable(cnt_rd_viol)));

  // R10: counters advance by at most one per edge
  p_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cnt_rd_miss == $past(cnt_rd_miss) ||
              cnt_rd_miss == $past(cnt_rd_miss) + 1'b1));

  // R11: a saturated counter stays saturated
  p_sat_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_rd_miss == TOP) |=> (cnt_rd_miss == TOP));

endmodule

bind xlat_guard xg_check #(.PA_W(PA_W), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_is_fetch (req_is_fetch),
  .lk_hit       (lk_hit),
  .phys_addr    (phys_addr),
  .flt_valid    (flt_valid),
  .flt_kind     (flt_kind),
  .flt_status   (flt_status),
  .cnt_rd_miss  (cnt_rd_miss),
  .cnt_rd_viol  (cnt_rd_viol)
);

// File: tb/sim_xlat_guard.sv
`timescale 1ns/1ps
module sim_xlat_guard;
  localparam int CW = 4;
  localparam int CMAX = 15;

  logic clk = 1'b0, rst_n = 1'b0;
  logic v, f, w, hit, fr, fw;
  logic [1:0] md;
  logic [31:0] va;
  logic [26:0] ppn;
  logic [3:0] rm, wm;
  logic [39:0] pa;
  logic fv;
  logic [1:0] fk;
  logic [3:0] fs;
  logic [CW-1:0] c_rm, c_wm, c_rv, c_wv;

  int n_chk = 0, n_bad = 0;
  int m_rm = 0, m_wm = 0, m_rv = 0, m_wv = 0;

  always #4 clk = ~clk;

  xlat_guard #(.CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(v), .req_is_fetch(f), .req_is_write(w),
    .priv_mode(md), .virt_addr(va), .lk_hit(hit), .ent_ppn(ppn),
    .ent_rd_mask(rm), .ent_wr_mask(wm), .ent_for(fr), .ent_fow(fw),
    .phys_addr(pa), .flt_valid(fv), .flt_kind(fk), .flt_status(fs),
    .cnt_rd_miss(c_rm), .cnt_wr_miss(c_wm), .cnt_rd_viol(c_rv), .cnt_wr_viol(c_wv)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic apply(input bit iv, input bit ifch, input bit iw, input int imd,
                       input longint iva, input bit ih, input longint ippn,
                       input int irm, input int iwm, input bit ifr, input bit ifw);
    longint epa;
    int ek, es;
    bit allowed;
    @(negedge clk);
    v = iv; f = ifch; w = iw; md = imd[1:0]; va = iva[31:0]; hit = ih;
    ppn = ippn[26:0]; rm = irm[3:0]; wm = iwm[3:0]; fr = ifr; fw = ifw;
    #1;
    // reference: address
    epa = ippn * 8192 + (iva % 8192);
    if (ifch) epa = epa - (epa % 4);
    // reference: fault classification
    ek = 0; es = 0;
    if (!ih) begin
      ek = 1;
      if (!ifch && iw) es = 1;
    end else if (ifch) begin
      allowed = ((irm >> imd) % 2) == 1;
      if (!allowed) ek = 2;
    end else if (iw) begin
      allowed = ((iwm >> imd) % 2) == 1;
      if (!allowed) begin ek = 2; es = 1 + 2 + (ifw ? 8 : 0); end
      else if (ifw) begin ek = 3; es = 9; end
    end else begin
      allowed = ((irm >> imd) % 2) == 1;
      if (!allowed) begin ek = 2; es = 2 + (ifr ? 4 : 0); end
      else if (ifr) begin ek = 3; es = 4; end
    end
    if (!iv) begin ek = 0; es = 0; end
    chk(ifch ? "R2 fetch address" : "R1 data address", pa, epa);
    chk("R3-R8 kind (R9 when quiet)", fk, ek);
    chk("R3-R8 status (R9 when quiet)", fs, es);
    chk("R9 fault valid", fv, ek != 0);
    chk("R10/R11 rd miss count", c_rm, m_rm);
    chk("R10/R11 wr miss count", c_wm, m_wm);
    chk("R10/R11 rd viol count", c_rv, m_rv);
    chk("R10/R11 wr viol count", c_wv, m_wv);
    if (iv && !ifch) begin
      if (ek == 1 && !iw && m_rm < CMAX) m_rm++;
      if (ek == 1 &&  iw && m_wm < CMAX) m_wm++;
      if (ek >= 2 && !iw && m_rv < CMAX) m_rv++;
      if (ek >= 2 &&  iw && m_wv < CMAX) m_wv++;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    v = 0; f = 0; w = 0; md = 0; va = 0; hit = 0; ppn = 0; rm = 0; wm = 0; fr = 0; fw = 0;
    repeat (3) @(negedge clk);
    // R12: counters clear during reset
    chk("R12 reset rd miss", c_rm, 0);
    chk("R12 reset wr viol", c_wv, 0);
    rst_n = 1'b1;
    // R1 data read hit, no fault
    apply(1, 0, 0, 0, 64'h1234_5ABC, 1, 27'h3_1234, 4'hF, 4'hF, 0, 0);
    // R2 fetch alignment
    apply(1, 1, 0, 3, 64'hFFFF_FFFF, 1, 27'h7FF_FFFF, 4'hF, 4'h0, 0, 0);
    // R3 misses: read, write, fetch
    apply(1, 0, 0, 1, 64'h10, 0, 1, 4'h0, 4'h0, 1, 1);
    apply(1, 0, 1, 1, 64'h20, 0, 2, 4'hF, 4'hF, 0, 0);
    apply(1, 1, 1, 1, 64'h30, 0, 3, 4'hF, 4'hF, 0, 0);
    // R4 write violation with and without fault-on-write
    apply(1, 0, 1, 2, 64'h44, 1, 5, 4'hF, 4'b1011, 0, 0);
    apply(1, 0, 1, 2, 64'h44, 1, 5, 4'hF, 4'b1011, 0, 1);
    // R5 write fault-on-write
    apply(1, 0, 1, 3, 64'h48, 1, 6, 4'h0, 4'b1000, 1, 1);
    // R6 read violation with and without fault-on-read
    apply(1, 0, 0, 1, 64'h50, 1, 7, 4'b1101, 4'hF, 0, 0);
    apply(1, 0, 0, 1, 64'h50, 1, 7, 4'b1101, 4'hF, 1, 1);
    // R7 read fault-on-read
    apply(1, 0, 0, 0, 64'h58, 1, 8, 4'b0001, 4'h0, 1, 0);
    // R8 fetch violation, and fetch ignoring flags / write mask
    apply(1, 1, 0, 2, 64'h60, 1, 9, 4'b1011, 4'hF, 0, 0);
    apply(1, 1, 1, 2, 64'h63, 1, 9, 4'b0100, 4'h0, 1, 1);
    // R9 idle with faulting inputs: nothing reported, counters hold
    apply(0, 0, 0, 0, 64'h70, 0, 10, 4'h0, 4'h0, 1, 1);
    apply(0, 0, 1, 0, 64'h70, 1, 10, 4'h0, 4'h0, 1, 1);
    // mixed patterns
    for (int i = 0; i < 400; i++) begin
      int r;
      r = $urandom;
      apply(r[0] | r[1], r[2], r[3], r[5:4], {32'd0, $urandom}, r[6] | r[7],
            {37'd0, $urandom % 134217728}, r[11:8], r[15:12], r[16], r[17]);
    end
    // R11 saturation of every counter
    for (int i = 0; i < 20; i++) apply(1, 0, 0, 0, 64'h0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 20; i++) apply(1, 0, 1, 0, 64'h0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 20; i++) apply(1, 0, 0, 0, 64'h0, 1, 0, 0, 0, 0, 0);
    for (int i = 0; i < 20; i++) apply(1, 0, 1, 0, 64'h0, 1, 0, 0, 0, 0, 0);
    apply(0, 0, 0, 0, 64'h0, 1, 0, 4'hF, 4'hF, 0, 0);
    chk("R11 rd miss saturated", c_rm, CMAX);
    chk("R11 wr viol saturated", c_wv, CMAX);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule